// File: doc/BRIEF.md
# Acquisition Sample FIFO with Status and Interrupt Unit

This block buffers 16-bit converter samples in a first-in, first-out store and publishes one read-only status word. The word gathers the FIFO flags, a sticky overflow flag, a sticky end-of-acquisition flag, a calibration-busy indication, a DMA terminal-count flag, the overall interrupt flag and a 2-bit board identity. From these flags the block raises an interrupt line and a DMA request. The enables that shape both come from a 16-bit control word written by the host.

The host reads samples through a first-word-fall-through port. A sample comes back exactly as it was stored, in two's complement, so a reader that wants offset binary inverts bit 15. Each flag has its own clear path. A FIFO-reset strobe empties the store and clears overflow and end of acquisition. A separate terminal-count-clear strobe drops the terminal-count flag. The host DMA controller is represented only by a one-cycle terminal-count pulse input.

The fill level is tracked by a four-state machine: FL_EMPTY, FL_LOW (1 to DEPTH/2-1 entries), FL_HALF (DEPTH/2 to DEPTH-1 entries) and FL_FULL. Every cycle the next state is picked from the next occupancy count, so each transition can take place. A push raises the level (FL_EMPTY to FL_LOW, FL_LOW to FL_HALF, FL_HALF to FL_FULL). A pop lowers it along the same path in reverse. The reset strobe returns any state to FL_EMPTY. A push and a pop in the same cycle hold the state.

Top module: `acq_fifo_irq_unit`

## Requirements
- R1: After reset the FIFO is empty, every flag is clear and the control word is zero, so the status word holds only the board identity in bits [9:8], and irq and dma_req are low.
- R2: Accepted samples are read back in arrival order and unchanged through the fall-through read port. Inverting bit 15 of a value read gives its offset-binary code (0x8001 reads as offset 0x0001, 0x7FFF as 0xFFFF).
- R3: A write that arrives while the FIFO is full, without a pop in the same cycle, is dropped and sets the overflow flag (status bit 3). The flag stays set until a FIFO reset. A push with a pop while full is accepted and does not set overflow.
- R4: Status layout: bit 0 not-empty, bit 1 half-full (occupancy at least DEPTH/2), bit 2 zero, bit 5 follows the calibration-busy input, bits [9:8] follow the board identity input, bits [15:10] zero.
- R5: A FIFO-reset strobe empties the FIFO and clears overflow and end of acquisition. It takes precedence over a write in the same cycle, and that write is lost.
- R6: A terminal-count pulse sets status bit 7. The terminal-count-clear strobe clears it. When both occur in the same cycle, the flag ends up set.
- R7: An end-of-acquisition pulse sets status bit 4, which stays set until a FIFO reset.
- R8: The interrupt (irq, mirrored in status bit 6) is the OR of the enabled events. Control bit 8 enables the data event, overflow and end of acquisition. The data event is not-empty, or half-full when control bit 9 is set. Control bit 11 enables the terminal-count event.
- R9: dma_req is low while control bit 3 is clear. When control bit 3 is set, dma_req follows not-empty if control bit 12 (demand mode) is set, and follows half-full otherwise.
- R10: The control word is latched on ctl_wr. Bits [2:0] appear on dma_chan and bits [7:4] on irq_lvl.
- R11: A read strobe on an empty FIFO is ignored: occupancy, flags and later data are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample write strobe from the converter |
| smp_data | input | DW | Sample, two's complement |
| rd_en | input | 1 | Host read strobe (pops the head entry) |
| rd_data | output | DW | Head entry of the FIFO (fall-through) |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word value |
| fifo_rst_wr | input | 1 | FIFO reset strobe |
| tc_clr_wr | input | 1 | Terminal-count clear strobe |
| tc_pulse | input | 1 | DMA terminal-count pulse from the host controller |
| eoa_pulse | input | 1 | End-of-acquisition pulse |
| cal_busy | input | 1 | Offset calibration in progress |
| board_id | input | 2 | Board identity code |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| dma_chan | output | 3 | DMA channel field of the control word |
| irq_lvl | output | 4 | Interrupt level field of the control word |

## Verification
The bench builds the block with DW=16 and DEPTH=8. At that depth the half-full boundary is at four entries and full is at eight. The FL_HALF and FL_FULL states, the dropped ninth write and the push-with-pop while full can therefore all be reached in a few dozen cycles. A vector table steps through the interrupt and DMA enable combinations. Directed tests then cover the same-cycle clear/set and reset/write collisions.

// File: rtl/acq_pkg.sv
package acq_pkg;

    // fill level states of the sample store
    typedef enum logic [1:0] {
        FL_EMPTY = 2'd0,
        FL_LOW   = 2'd1,
        FL_HALF  = 2'd2,
        FL_FULL  = 2'd3
    } fill_state_t;

    // decoded host control word
    typedef struct packed {
        logic       demand;
        logic       tc_ie;
        logic       half_sel;
        logic       fifo_ie;
        logic [3:0] irq_lvl;
        logic       dma_en;
        logic [2:0] dma_chan;
    } ctl_t;

    // control word bit positions
    localparam int CB_DMA_EN   = 3;
    localparam int CB_FIFO_IE  = 8;
    localparam int CB_HALF_SEL = 9;
    localparam int CB_TC_IE    = 11;
    localparam int CB_DEMAND   = 12;

    // status word bit positions
    localparam int SB_NE   = 0;
    localparam int SB_HALF = 1;
    localparam int SB_OVFL = 3;
    localparam int SB_EOA  = 4;
    localparam int SB_CAL  = 5;
    localparam int SB_IRQ  = 6;
    localparam int SB_TC   = 7;

    function automatic ctl_t ctl_decode(input logic [15:0] w);
        ctl_t c;
        c.dma_chan = w[2:0];
        c.dma_en   = w[CB_DMA_EN];
        c.irq_lvl  = w[7:4];
        c.fifo_ie  = w[CB_FIFO_IE];
        c.half_sel = w[CB_HALF_SEL];
        c.tc_ie    = w[CB_TC_IE];
        c.demand   = w[CB_DEMAND];
        return c;
    endfunction

endpackage

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo
    import acq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          not_empty,
    output logic          half,
    output logic          full,
    output logic          overrun
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;
    localparam logic [CW-1:0] HALF_C  = CW'(HALF);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt, cnt_nxt;
    fill_state_t   state, state_nxt;
    logic          do_push, do_pop;

    assign do_pop  = pop & not_empty & ~clr;
    assign do_push = push & (~full | pop) & ~clr;
    assign overrun = push & full & ~pop & ~clr;

    always_comb begin
        if (clr)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + CW'(do_push) - CW'(do_pop);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_EMPTY;
        else        state <= state_nxt;
    end

    // next state from next occupancy
    always_comb begin
        if (cnt_nxt == '0)            state_nxt = FL_EMPTY;
        else if (cnt_nxt == DEPTH_C)  state_nxt = FL_FULL;
        else if (cnt_nxt >= HALF_C)   state_nxt = FL_HALF;
        else                          state_nxt = FL_LOW;
    end

    // outputs from state
    always_comb begin
        not_empty = 1'b1;
        half      = 1'b0;
        full      = 1'b0;
        unique case (state)
            FL_EMPTY: not_empty = 1'b0;
            FL_LOW:   ;
            FL_HALF:  half = 1'b1;
            FL_FULL: begin
                half = 1'b1;
                full = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (clr) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + AW'(1);
                if (do_pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/acq_event_flags.sv
module acq_event_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_clr,
    input  logic overrun,
    input  logic eoa_pulse,
    input  logic tc_pulse,
    input  logic tc_clr,
    output logic ovfl,
    output logic eoa,
    output logic tc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovfl <= 1'b0;
            eoa  <= 1'b0;
            tc   <= 1'b0;
        end else begin
            if (fifo_clr)       ovfl <= 1'b0;
            else if (overrun)   ovfl <= 1'b1;

            if (fifo_clr)       eoa <= 1'b0;
            else if (eoa_pulse) eoa <= 1'b1;

            if (tc_pulse)       tc <= 1'b1;
            else if (tc_clr)    tc <= 1'b0;
        end
    end
endmodule

// File: rtl/acq_irq_dma.sv
module acq_irq_dma
    import acq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    input  logic        not_empty,
    input  logic        half,
    input  logic        ovfl,
    input  logic        eoa,
    input  logic        tc,
    output logic        irq,
    output logic        dma_req,
    output logic [2:0]  dma_chan,
    output logic [3:0]  irq_lvl
);
    ctl_t ctl;
    logic data_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_wr) ctl <= ctl_decode(ctl_wdata);
    end

    always_comb begin
        data_evt = ctl.half_sel ? half : not_empty;
        irq      = (ctl.fifo_ie & (data_evt | ovfl | eoa)) | (ctl.tc_ie & tc);
        dma_req  = ctl.dma_en & (ctl.demand ? not_empty : half);
    end

    assign dma_chan = ctl.dma_chan;
    assign irq_lvl  = ctl.irq_lvl;
endmodule

// File: rtl/acq_fifo_irq_unit.sv
module acq_fifo_irq_unit
    import acq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          ctl_wr,
    input  logic [15:0]   ctl_wdata,
    input  logic          fifo_rst_wr,
    input  logic          tc_clr_wr,
    input  logic          tc_pulse,
    input  logic          eoa_pulse,
    input  logic          cal_busy,
    input  logic [1:0]    board_id,
    output logic [15:0]   status,
    output logic          irq,
    output logic          dma_req,
    output logic [2:0]    dma_chan,
    output logic [3:0]    irq_lvl
);
    logic fifo_ne, fifo_half, fifo_full, fifo_overrun;
    logic ovfl, eoa, tc;

    acq_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_rst_wr),
        .push      (smp_valid),
        .wdata     (smp_data),
        .pop       (rd_en),
        .rdata     (rd_data),
        .not_empty (fifo_ne),
        .half      (fifo_half),
        .full      (fifo_full),
        .overrun   (fifo_overrun)
    );

    acq_event_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_clr  (fifo_rst_wr),
        .overrun   (fifo_overrun),
        .eoa_pulse (eoa_pulse),
        .tc_pulse  (tc_pulse),
        .tc_clr    (tc_clr_wr),
        .ovfl      (ovfl),
        .eoa       (eoa),
        .tc        (tc)
    );

    acq_irq_dma u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .not_empty (fifo_ne),
        .half      (fifo_half),
        .ovfl      (ovfl),
        .eoa       (eoa),
        .tc        (tc),
        .irq       (irq),
        .dma_req   (dma_req),
        .dma_chan  (dma_chan),
        .irq_lvl   (irq_lvl)
    );

    always_comb begin
        status          = '0;
        status[SB_NE]   = fifo_ne;
        status[SB_HALF] = fifo_half;
        status[SB_OVFL] = ovfl;
        status[SB_EOA]  = eoa;
        status[SB_CAL]  = cal_busy;
        status[SB_IRQ]  = irq;
        status[SB_TC]   = tc;
        status[9:8]     = board_id;
    end

endmodule

// File: rtl/acq_fifo_irq_checker.sv
module acq_fifo_irq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        smp_valid,
    input logic        rd_en,
    input logic        fifo_rst_wr,
    input logic        tc_pulse,
    input logic        tc_clr_wr,
    input logic        eoa_pulse,
    input logic [15:0] status,
    input logic        irq,
    input logic        dma_req,
    input logic        full
);
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && smp_valid && !fifo_rst_wr) |=> status[0]);

    assert_overrun_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && smp_valid && !rd_en && !fifo_rst_wr) |=> status[3]);

    assert_ovfl_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !fifo_rst_wr) |=> status[3]);

    assert_half_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> status[0]);

    assert_reset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst_wr |=> (!status[0] && !status[3] && !status[4]));

    assert_tc_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> status[7]);

    assert_tc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr_wr && !tc_pulse) |=> !status[7]);

    assert_eoa_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoa_pulse && !fifo_rst_wr) |=> status[4]);

    assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[0] || status[3] || status[4] || status[7]));

    assert_no_req_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] |-> !dma_req);

    assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && rd_en && !smp_valid) |=> !status[0]);
endmodule

bind acq_fifo_irq_unit acq_fifo_irq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .rd_en       (rd_en),
    .fifo_rst_wr (fifo_rst_wr),
    .tc_pulse    (tc_pulse),
    .tc_clr_wr   (tc_clr_wr),
    .eoa_pulse   (eoa_pulse),
    .status      (status),
    .irq         (irq),
    .dma_req     (dma_req),
    .full        (fifo_full)
);

// File: tb/acq_fifo_irq_unit_tb.sv
module acq_fifo_irq_unit_tb;
    localparam int DW    = 16;
    localparam int DEPTH = 8;

    localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_CTL = 3'd2,
                           OP_TC = 3'd3, OP_TCCLR = 3'd4, OP_EOA = 3'd5,
                           OP_FRST = 3'd6;

    // {op, arg, expected status, expected irq, expected dma_req}
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {OP_CTL,   16'h0108, 16'h0200, 1'b0, 1'b0},
        {OP_PUSH,  16'h8001, 16'h0241, 1'b1, 1'b0},
        {OP_PUSH,  16'h0002, 16'h0241, 1'b1, 1'b0},
        {OP_PUSH,  16'h0003, 16'h0241, 1'b1, 1'b0},
        {OP_PUSH,  16'h0004, 16'h0243, 1'b1, 1'b1},
        {OP_CTL,   16'h1308, 16'h0243, 1'b1, 1'b1},
        {OP_POP,   16'h0000, 16'h0201, 1'b0, 1'b1},
        {OP_CTL,   16'h0800, 16'h0201, 1'b0, 1'b0},
        {OP_TC,    16'h0000, 16'h02C1, 1'b1, 1'b0},
        {OP_TCCLR, 16'h0000, 16'h0201, 1'b0, 1'b0},
        {OP_EOA,   16'h0000, 16'h0211, 1'b0, 1'b0},
        {OP_FRST,  16'h0000, 16'h0200, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          ctl_wr = 1'b0;
    logic [15:0]   ctl_wdata = '0;
    logic          fifo_rst_wr = 1'b0;
    logic          tc_clr_wr = 1'b0;
    logic          tc_pulse = 1'b0;
    logic          eoa_pulse = 1'b0;
    logic          cal_busy = 1'b0;
    logic [1:0]    board_id = 2'b10;
    logic [15:0]   status;
    logic          irq, dma_req;
    logic [2:0]    dma_chan;
    logic [3:0]    irq_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acq_fifo_irq_unit #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .rd_en(rd_en), .rd_data(rd_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .fifo_rst_wr(fifo_rst_wr), .tc_clr_wr(tc_clr_wr), .tc_pulse(tc_pulse),
        .eoa_pulse(eoa_pulse), .cal_busy(cal_busy), .board_id(board_id),
        .status(status), .irq(irq), .dma_req(dma_req), .dma_chan(dma_chan),
        .irq_lvl(irq_lvl)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        smp_valid = 1'b0; rd_en = 1'b0; ctl_wr = 1'b0; fifo_rst_wr = 1'b0;
        tc_clr_wr = 1'b0; tc_pulse = 1'b0; eoa_pulse = 1'b0;
    endtask

    // inputs set at a negedge, captured at the next posedge, released and
    // checked at the following negedge
    task automatic step(input logic [2:0] op, input logic [15:0] arg);
        unique case (op)
            OP_PUSH:  begin smp_valid = 1'b1; smp_data = arg; end
            OP_POP:   rd_en = 1'b1;
            OP_CTL:   begin ctl_wr = 1'b1; ctl_wdata = arg; end
            OP_TC:    tc_pulse = 1'b1;
            OP_TCCLR: tc_clr_wr = 1'b1;
            OP_EOA:   eoa_pulse = 1'b1;
            default:  fifo_rst_wr = 1'b1;
        endcase
        @(negedge clk);
        idle();
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", status, 16'h0200);
        check("R1 irq", {15'b0, irq}, 16'h0);
        check("R1 dma", {15'b0, dma_req}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after release", status, 16'h0200);

        // vector table: R4 R7 R8 R9 R6 R5
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][36:34], VEC[i][33:18]);
            check($sformatf("R8 vec%0d status", i), status, VEC[i][17:2]);
            check($sformatf("R8 vec%0d irq", i), {15'b0, irq}, {15'b0, VEC[i][1]});
            check($sformatf("R9 vec%0d dma", i), {15'b0, dma_req}, {15'b0, VEC[i][0]});
        end

        // R2 order, value and offset-binary view
        step(OP_PUSH, 16'h8001);
        step(OP_PUSH, 16'h7FFF);
        step(OP_PUSH, 16'h0000);
        check("R2 head", rd_data, 16'h8001);
        check("R2 offset", rd_data ^ 16'h8000, 16'h0001);
        step(OP_POP, 16'h0);
        check("R2 second", rd_data, 16'h7FFF);
        check("R2 offset max", rd_data ^ 16'h8000, 16'hFFFF);
        step(OP_POP, 16'h0);
        check("R2 third", rd_data, 16'h0000);
        step(OP_POP, 16'h0);
        check("R2 drained", status, 16'h0200);

        // R11 pop on empty
        step(OP_POP, 16'h0);
        check("R11 empty pop status", status, 16'h0200);
        step(OP_PUSH, 16'h0ABC);
        check("R11 data intact", rd_data, 16'h0ABC);
        step(OP_POP, 16'h0);

        // R3 overflow
        step(OP_CTL, 16'h0100);
        for (int i = 0; i < DEPTH; i++) step(OP_PUSH, 16'h1000 + 16'(i));
        check("R3 full no ovfl", status, 16'h0243);
        smp_valid = 1'b1; smp_data = 16'h3333; rd_en = 1'b1;
        @(negedge clk);
        idle();
        check("R3 push+pop at full", status, 16'h0243);
        step(OP_PUSH, 16'h2222);
        check("R3 overflow set", status, 16'h024B);
        for (int i = 1; i < DEPTH; i++) begin
            check("R3 kept data", rd_data, 16'h1000 + 16'(i));
            step(OP_POP, 16'h0);
        end
        check("R3 dropped sample absent", rd_data, 16'h3333);
        step(OP_POP, 16'h0);
        check("R3 sticky after drain", status, 16'h0248);
        check("R8 irq on overflow", {15'b0, irq}, 16'h1);

        // R5 reset wins over same-cycle write
        smp_valid = 1'b1; smp_data = 16'h5555; fifo_rst_wr = 1'b1;
        @(negedge clk);
        idle();
        check("R5 reset with write", status, 16'h0200);

        // R6 set and clear together
        tc_pulse = 1'b1; tc_clr_wr = 1'b1;
        @(negedge clk);
        idle();
        check("R6 set wins", status, 16'h0280);
        step(OP_TCCLR, 16'h0);
        check("R6 cleared", status, 16'h0200);

        // R4 calibration busy
        cal_busy = 1'b1;
        @(negedge clk);
        check("R4 cal bit", status, 16'h0220);
        cal_busy = 1'b0;

        // R10 field outputs
        step(OP_CTL, 16'hFFFF);
        check("R10 dma_chan", {13'b0, dma_chan}, 16'h7);
        check("R10 irq_lvl", {12'b0, irq_lvl}, 16'hF);
        step(OP_CTL, 16'h00A5);
        check("R10 dma_chan 5", {13'b0, dma_chan}, 16'h5);
        check("R10 irq_lvl A", {12'b0, irq_lvl}, 16'hA);

        // R9 DMA disabled vs enabled in demand mode
        step(OP_CTL, 16'h1000);
        step(OP_PUSH, 16'h0001);
        check("R9 dma off", {15'b0, dma_req}, 16'h0);
        step(OP_CTL, 16'h1008);
        check("R9 demand on", {15'b0, dma_req}, 16'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule